// File: doc/BRIEF.md
# Folded Five-Tap Binomial Smoothing Filter

This block smooths a stream of unsigned samples with the five-tap binomial kernel 1,4,6,4,1, the fourth power of the two-tap pulse (1,1). A plain implementation chains four add-and-delay stages. This design folds those four stages onto two adders instead. Each adder has a multiplexer on its operands. In one clock phase the two adders evaluate the first and second stages. In the other phase they evaluate the third and fourth stages from registered partial results. The price is throughput: a sample enters at most every second clock and a result leaves at most every second clock.

Samples enter over a ready/valid handshake. The block holds ready low during the second phase, so an upstream source simply waits. Each result appears on the output for one clock, marked by a valid pulse. It stays on the data lines until the next result replaces it. The output is full precision and four bits wider than the input, so no result saturates or is rounded. Gaps in the input stream are allowed and do not change the results: the output sequence equals the four-stage cascade applied to the accepted samples only.

Top module: `binf_serial_top`

## Requirements
- R1: While reset is held, and after reset is released, all history is zero. The first result after reset equals the first accepted sample. Both out_valid and out_data read 0 until the first result. in_ready is 0 while rst_n is low and reaches 1 within three clocks of its release.
- R2: A sample is accepted on a rising edge where in_valid and in_ready are both 1. In the clock after an acceptance, in_ready is 0.
- R3: Two consecutive rising edges never both accept a sample. in_ready is 1 again in the clock after the idle phase.
- R4: The result for an accepted sample appears with out_valid high during the second clock after the accepting edge (latency of two edges). out_valid is never high in two consecutive clocks.
- R5: For accepted samples x[n], the n-th result is x[n] + 4·x[n-1] + 6·x[n-2] + 4·x[n-3] + x[n-4], with samples older than the first one treated as 0. An impulse therefore yields 1,4,6,4,1.
- R6: A clock in the accept phase with in_valid low changes no state. Gaps of any length leave later results equal to R5 over the accepted samples.
- R7: While out_valid is 0, out_data keeps the last result.
- R8: The output holds sixteen times the largest input without overflow. A run of five all-ones samples ends in 16·(2^DW−1).
- R9: A value presented with in_valid high while in_ready is 0 is ignored and never enters any later result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take a sample on this edge |
| in_data | input | DW | Unsigned input sample |
| out_valid | output | 1 | One-clock pulse marking a new result |
| out_data | output | DW+4 | Full-precision filtered result |

## Verification
The hardest situation to reach is a sample sitting on the input with valid high during the idle phase. The input must be ignored there, and the folded registers must still carry exactly the right history. The bench reaches this by keeping in_valid high with a decoy value in the clock right after an acceptance. It then checks that the following results match the cascade model built without the decoy. Stalls of several clocks in the accept phase are mixed into the stream. A reset is applied in the middle of a stream to show that the history clears.

// File: rtl/binf_pkg.sv
`timescale 1ns/1ps
package binf_pkg;
  typedef enum logic {PH_TAKE = 1'b0, PH_FOLD = 1'b1} phase_e;
  localparam int unsigned N_STAGES = 4;
  localparam int unsigned N_LANES  = 2;
  localparam int unsigned N_TAPS   = N_STAGES;
  localparam int unsigned GROWTH   = N_STAGES;
  localparam int unsigned OUT_LAT  = 2;
endpackage

// File: rtl/binf_phase_ctrl.sv
`timescale 1ns/1ps
module binf_phase_ctrl
  import binf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  output logic take,
  output logic fold
);
  phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_TAKE: if (in_valid) phase_d = PH_FOLD;
      PH_FOLD: phase_d = PH_TAKE;
      default: phase_d = PH_TAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_TAKE;
    else        phase_q <= phase_d;
  end

  assign in_ready = rst_n && (phase_q == PH_TAKE);
  assign take     = in_ready && in_valid;
  assign fold     = (phase_q == PH_FOLD);

  assert_no_back2back_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (fold && !in_ready));
  assert_ready_returns_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fold |=> in_ready);
endmodule

// File: rtl/binf_lane.sv
`timescale 1ns/1ps
module binf_lane #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel_fold,
  input  logic [W-1:0] a_take,
  input  logic [W-1:0] b_take,
  input  logic [W-1:0] a_fold,
  input  logic [W-1:0] b_fold,
  output logic [W-1:0] sum
);
  logic [W-1:0] op_a, op_b;
  logic [W:0]   wide;

  always_comb begin
    op_a = sel_fold ? a_fold : a_take;
    op_b = sel_fold ? b_fold : b_take;
    wide = {1'b0, op_a} + {1'b0, op_b};
  end

  assign sum = wide[W-1:0];

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wide[W]);
endmodule

// File: rtl/binf_history.sv
`timescale 1ns/1ps
module binf_history
  import binf_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic         fold,
  input  logic [W-1:0] x_ext,
  input  logic [W-1:0] sum_lo,
  input  logic [W-1:0] sum_hi,
  output logic [N_TAPS-1:0][W-1:0] taps,
  output logic [W-1:0] mid,
  output logic [W-1:0] y,
  output logic         y_valid
);
  logic [N_TAPS-1:0][W-1:0] tap_q, tap_d;
  logic [W-1:0] mid_q, mid_d, y_q, y_d;
  logic         yv_q, yv_d;

  always_comb begin
    tap_d = tap_q;
    mid_d = mid_q;
    y_d   = y_q;
    yv_d  = 1'b0;
    if (take) begin
      tap_d[0] = x_ext;
      tap_d[1] = sum_lo;
      mid_d    = sum_hi;
    end
    if (fold) begin
      tap_d[2] = mid_q;
      tap_d[3] = sum_lo;
      y_d      = sum_hi;
      yv_d     = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_q <= '0;
      mid_q <= '0;
      y_q   <= '0;
      yv_q  <= 1'b0;
    end else begin
      tap_q <= tap_d;
      mid_q <= mid_d;
      y_q   <= y_d;
      yv_q  <= yv_d;
    end
  end

  assign taps    = tap_q;
  assign mid     = mid_q;
  assign y       = y_q;
  assign y_valid = yv_q;

  assert_stall_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !fold) |=> ($stable(tap_q) && $stable(mid_q)));
endmodule

// File: rtl/binf_serial_top.sv
`timescale 1ns/1ps
module binf_serial_top
  import binf_pkg::*;
#(
  parameter int unsigned DW = 8,
  localparam int unsigned OW = DW + GROWTH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [OW-1:0] out_data
);
  logic [1:0] rsync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i = rsync_q[1];

  logic take, fold;
  logic [OW-1:0] x_ext, mid;
  logic [N_TAPS-1:0][OW-1:0] taps;
  logic [N_LANES-1:0][OW-1:0] a_take, b_take, a_fold, b_fold, lane_sum;

  binf_phase_ctrl u_phase (
    .clk(clk), .rst_n(rst_i), .in_valid(in_valid),
    .in_ready(in_ready), .take(take), .fold(fold)
  );

  assign x_ext = {{GROWTH{1'b0}}, in_data};

  always_comb begin
    a_take[0] = x_ext;        b_take[0] = taps[0];
    a_fold[0] = mid;          b_fold[0] = taps[2];
    a_take[1] = lane_sum[0];  b_take[1] = taps[1];
    a_fold[1] = lane_sum[0];  b_fold[1] = taps[3];
  end

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    binf_lane #(.W(OW)) u_lane (
      .clk(clk), .rst_n(rst_i), .sel_fold(fold),
      .a_take(a_take[g]), .b_take(b_take[g]),
      .a_fold(a_fold[g]), .b_fold(b_fold[g]),
      .sum(lane_sum[g])
    );
  end

  binf_history #(.W(OW)) u_hist (
    .clk(clk), .rst_n(rst_i), .take(take), .fold(fold),
    .x_ext(x_ext), .sum_lo(lane_sum[0]), .sum_hi(lane_sum[1]),
    .taps(taps), .mid(mid), .y(out_data), .y_valid(out_valid)
  );

  assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_i)
    out_valid |-> $past(take, OUT_LAT));
  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_i)
    out_valid |=> !out_valid);
  assert_hold_output_R7: assert property (@(posedge clk) disable iff (!rst_i)
    !out_valid |-> $stable(out_data));
endmodule

// File: tb/sim_binf_serial_top.sv
`timescale 1ns/1ps
module sim_binf_serial_top;
  localparam int DW = 8;
  localparam int OW = DW + 4;
  localparam int NV = 16;
  localparam logic [DW-1:0] VEC [NV] = '{8'd1, 8'd0, 8'd0, 8'd0, 8'd0, 8'd200,
    8'd13, 8'd77, 8'd255, 8'd0, 8'd128, 8'd64, 8'd3, 8'd250, 8'd9, 8'd100};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [DW-1:0] in_data = '0;
  logic out_valid;
  logic [OW-1:0] out_data;

  int total = 0;
  int bad = 0;
  int hist [5];

  always #2.5 clk = ~clk;

  binf_serial_top #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 5; i++) hist[i] = 0;
  endtask

  task automatic push(input logic [DW-1:0] x, input bit noise, input string rq);
    int exp;
    for (int i = 4; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = x;
    exp = hist[0] + 4*hist[1] + 6*hist[2] + 4*hist[3] + hist[4];
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = x;
    @(negedge clk);
    chk(in_ready == 1'b0, "R2", in_ready, 0);
    chk(out_valid == 1'b0, "R4", out_valid, 0);
    if (noise) begin
      in_valid = 1'b1;
      in_data  = 8'hA5;
    end else begin
      in_valid = 1'b0;
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R4", out_valid, 1);
    chk(out_data == OW'(exp), rq, out_data, exp);
    chk(in_ready == 1'b1, "R3", in_ready, 1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    model_clear();
    @(negedge clk);
    chk(in_ready == 1'b0, "R1", in_ready, 0);
    chk(out_valid == 1'b0, "R1", out_valid, 0);
    chk(out_data == '0, "R1", out_data, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R1", in_ready, 1);
    chk(out_valid == 1'b0, "R1", out_valid, 0);
  endtask

  initial begin
    #500us;
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [OW-1:0] held;
    model_clear();
    repeat (3) @(negedge clk);
    do_reset();

    // R5: table walk at full rate, impulse at the head
    for (int i = 0; i < NV; i++) push(VEC[i], 1'b0, "R5");

    // R6 and R7: stall in the accept phase
    held = out_data;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R6", out_valid, 0);
      chk(out_data == held, "R7", out_data, held);
    end
    push(8'd42, 1'b0, "R6");
    push(8'd17, 1'b0, "R6");

    // R9: decoy value during the idle phase
    push(8'd5, 1'b1, "R9");
    push(8'd90, 1'b1, "R9");
    push(8'd0, 1'b0, "R9");
    push(8'd0, 1'b0, "R9");

    // R8: all-ones run
    for (int i = 0; i < 5; i++) push(8'hFF, 1'b0, "R8");
    chk(out_data == OW'(16*255), "R8", out_data, 16*255);

    // R1: reset mid-stream clears history
    do_reset();
    push(8'd7, 1'b0, "R1");
    push(8'd0, 1'b0, "R1");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule